// File: doc/BRIEF.md
# Cascaded CAM Status Flag Unit

This block derives the status flags of one content-addressable memory device that sits in a vertical chain of such devices. After each compare it looks at the per-entry match results, keeps only matches against entries marked valid, and registers two device-local flags. Both are active-low. One says that at least one valid entry matched. The other says that two or more did. The flags hold until the next compare strobe, and they are cleared when the active register set changes.

The block also joins the two daisy chains that run through the stack. On the priority chain, a match in any device above, or a match held here, pulls the match-out line low, so devices further down lose priority. On the fullness chain, full-out goes low only when this device has no empty entry and every device above it is full. Software can turn off full flagging, and then full-out simply repeats full-in. A next-free indication marks the single device in the chain that holds the next free location. The first device in a chain has its match-in tied high and its full-in tied low.

Top module: `cam_flag_unit`

## Requirements
- R1: `ma_n` is low after a compare strobe exactly when at least one entry has both its `entry_valid` bit and its `entry_hit` bit at 1. A hit on an entry whose valid bit is 0 is not counted.
- R2: `mm_n` is low after a compare strobe exactly when two or more entries have both their valid bit and their hit bit at 1.
- R3: `ma_n` and `mm_n` change only on the rising clock edge at which `cmp_stb` is 1. They keep their value for as long as `cmp_stb` stays 0, whatever `entry_hit` and `entry_valid` do.
- R4: A `set_chg` pulse sets `ma_n` and `mm_n` high at the next rising edge. It wins over a `cmp_stb` that arrives in the same cycle.
- R5: `ma_n` and `mm_n` depend on neither `mi_n` nor `full_en`.
- R6: With `full_en` at 1, `fo_n` is low exactly when `fi_n` is low and no bit of `entry_empty` is 1.
- R7: With `full_en` at 0, `fo_n` equals `fi_n`.
- R8: `next_free` is 1 exactly when `fi_n` is low and `fo_n` is high.
- R9: `mo_n` is low exactly when `mi_n` is low or `ma_n` is low.
- R10: Reset is synchronous and active-low. While `rst_n` is 0, each rising edge sets `ma_n` and `mm_n` high. Driving `rst_n` low does not change them before that edge.
- R11: With the first-device inputs (`mi_n` at 1, `fi_n` at 0), `mo_n` follows `ma_n`. With full flagging on, `next_free` is 1 exactly when this device has an empty entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| entry_valid | input | ENTRIES | Per-entry valid bit |
| entry_empty | input | ENTRIES | Per-entry empty bit |
| entry_hit | input | ENTRIES | Per-entry result of the current compare |
| cmp_stb | input | 1 | Compare strobe; captures the flags |
| set_chg | input | 1 | Pulse when the active register set changes |
| full_en | input | 1 | Enables full flagging |
| mi_n | input | 1 | Match-in from the device above, active low |
| fi_n | input | 1 | Full-in from the device above, active low |
| ma_n | output | 1 | Device match flag, active low |
| mm_n | output | 1 | Device multiple-match flag, active low |
| mo_n | output | 1 | Match-out to the device below, active low |
| fo_n | output | 1 | Full-out to the device below, active low |
| next_free | output | 1 | This device holds the chain's next free location |

## Verification
The bench uses a four-entry configuration. It sweeps every pairing of valid vector and hit vector, so the match flags are tried with zero, one and several matching entries, and also with hits that fall only on invalid entries. This separates the one-match case from the several-match case, and shows that invalid hits are ignored. After every capture, the hit vector is overwritten without a strobe, to show that the flags hold. During the sweep, match-in and the full enable toggle, which shows that the device flags take no part in the chain signals. A second sweep covers every empty vector against every setting of full enable and full-in. The all-occupied vector is the only one that can drive full-out low, and this sweep tells the enabled chain apart from pass-through. The sweep includes the first-device tie-offs, and it also covers register-set clears that coincide with a compare and a reset asserted in the middle of a run.

// File: rtl/cflag_pkg.sv
// Shared types for the cascaded CAM status flag unit.
// Assumes: flags are kept active-high inside; only the top inverts them.
package cflag_pkg;

    // Summary of one compare: at least one valid hit, two or more valid hits.
    typedef struct packed {
        logic any;
        logic multi;
    } hit_sum_t;

endpackage

// File: rtl/cflag_hit_sum.sv
// Reduces the per-entry compare result to "one or more" and "two or more"
// valid hits.
// Assumes: a hit only counts where the entry's valid bit is set.
module cflag_hit_sum
    import cflag_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] hit,
    output hit_sum_t           sum
);

    logic [ENTRIES-1:0] qual;

    // Keep only the hits on valid entries.
    assign qual = valid & hit;

    // Linear scan: a second hit raises multi once any is already set.
    always_comb begin
        sum = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (qual[i]) begin
                sum.multi = sum.multi | sum.any;
                sum.any   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cflag_hold.sv
// Holds the compare summary from the last strobe.
// Assumes: a register-set change clears the summary and wins over a strobe
// in the same cycle; reset is synchronous and active low.
module cflag_hold
    import cflag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmp_stb,
    input  logic     set_chg,
    input  hit_sum_t sum,
    output hit_sum_t held
);

    // Capture on a strobe, clear on a set change or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (set_chg) held <= '0;
        else if (cmp_stb) held <= sum;
    end

endmodule

// File: rtl/cflag_full_chain.sv
// Fullness chain stage: forms full-out from this device's empty vector and
// full-in, and marks the device that holds the next free location.
// Assumes: full-in is active low and is tied low on the first device.
module cflag_full_chain #(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES-1:0] empty,
    input  logic               full_en,
    input  logic               fi_n,
    output logic               fo_n,
    output logic               next_free
);

    logic dev_full;

    // The device is full when no entry reports empty.
    assign dev_full = ~(|empty);

    // Chain full when enabled; plain pass-through otherwise.
    always_comb begin
        if (full_en) fo_n = ~(dev_full & ~fi_n);
        else         fo_n = fi_n;
    end

    // Next free sits where the chain above is full but this stage is not.
    assign next_free = ~fi_n & fo_n;

endmodule

// File: rtl/cam_flag_unit.sv
// Top of the cascaded CAM status flag unit: device match flags and the
// match and fullness daisy chains.
// Assumes: all chain signals are active low; the first device has mi_n=1
// and fi_n=0.
module cam_flag_unit
    import cflag_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] entry_valid,
    input  logic [ENTRIES-1:0] entry_empty,
    input  logic [ENTRIES-1:0] entry_hit,
    input  logic               cmp_stb,
    input  logic               set_chg,
    input  logic               full_en,
    input  logic               mi_n,
    input  logic               fi_n,
    output logic               ma_n,
    output logic               mm_n,
    output logic               mo_n,
    output logic               fo_n,
    output logic               next_free
);

    hit_sum_t cur_sum;
    hit_sum_t held_sum;

    cflag_hit_sum #(.ENTRIES(ENTRIES)) i_sum (
        .valid (entry_valid),
        .hit   (entry_hit),
        .sum   (cur_sum)
    );

    cflag_hold i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_stb (cmp_stb),
        .set_chg (set_chg),
        .sum     (cur_sum),
        .held    (held_sum)
    );

    cflag_full_chain #(.ENTRIES(ENTRIES)) i_full (
        .empty     (entry_empty),
        .full_en   (full_en),
        .fi_n      (fi_n),
        .fo_n      (fo_n),
        .next_free (next_free)
    );

    // Device flags leave the block active low.
    assign ma_n = ~held_sum.any;
    assign mm_n = ~held_sum.multi;

    // Priority chain: a match above or a held match here pulls match-out low.
    assign mo_n = mi_n & ~held_sum.any;

endmodule

// File: rtl/cam_flag_unit_chk.sv
// Property checker for cam_flag_unit, bound to every instance.
// Assumes: sampled on the rising clock edge, idle while rst_n is low.
module cam_flag_unit_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ENTRIES-1:0] entry_valid,
    input logic [ENTRIES-1:0] entry_hit,
    input logic               cmp_stb,
    input logic               set_chg,
    input logic               full_en,
    input logic               mi_n,
    input logic               fi_n,
    input logic               ma_n,
    input logic               mm_n,
    input logic               mo_n,
    input logic               fo_n,
    input logic               next_free
);

    // R1
    valid_hit_sets_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && !set_chg && (|(entry_valid & entry_hit))) |=> !ma_n);

    // R2
    multi_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mm_n |-> !ma_n);

    // R3
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_stb && !set_chg) |=> ($stable(ma_n) && $stable(mm_n)));

    // R4
    set_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_chg |=> (ma_n && mm_n));

    // R7
    full_pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_en |-> (fo_n == fi_n));

    // R8
    next_free_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fi_n |-> !next_free);

    // R9
    match_in_propagates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mi_n || !ma_n) |-> !mo_n);

endmodule

bind cam_flag_unit cam_flag_unit_chk #(.ENTRIES(ENTRIES)) i_cam_flag_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_valid (entry_valid),
    .entry_hit   (entry_hit),
    .cmp_stb     (cmp_stb),
    .set_chg     (set_chg),
    .full_en     (full_en),
    .mi_n        (mi_n),
    .fi_n        (fi_n),
    .ma_n        (ma_n),
    .mm_n        (mm_n),
    .mo_n        (mo_n),
    .fo_n        (fo_n),
    .next_free   (next_free)
);

// File: tb/test_cam_flag_unit.sv
// Self-checking bench: exhaustive sweeps on a four-entry configuration.
module test_cam_flag_unit;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] entry_valid, entry_empty, entry_hit;
    logic         cmp_stb, set_chg, full_en, mi_n, fi_n;
    logic         ma_n, mm_n, mo_n, fo_n, next_free;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    cam_flag_unit #(.ENTRIES(N)) i_cam_flag_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_valid (entry_valid),
        .entry_empty (entry_empty),
        .entry_hit   (entry_hit),
        .cmp_stb     (cmp_stb),
        .set_chg     (set_chg),
        .full_en     (full_en),
        .mi_n        (mi_n),
        .fi_n        (fi_n),
        .ma_n        (ma_n),
        .mm_n        (mm_n),
        .mo_n        (mo_n),
        .fo_n        (fo_n),
        .next_free   (next_free)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; entry_valid = '0; entry_empty = '0; entry_hit = '0;
        cmp_stb = 1'b0; set_chg = 1'b0; full_en = 1'b1; mi_n = 1'b1; fi_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset ma_n", ma_n, 1'b1);
        check("R10 reset mm_n", mm_n, 1'b1);
        check("R10 reset mo_n", mo_n, 1'b1);
        rst_n = 1'b1;

        // Match sweep: every valid vector against every hit vector.
        for (int v = 0; v < 16; v++) begin
            for (int h = 0; h < 16; h++) begin
                int n;
                logic exp_ma, exp_mm;
                n = $countones(4'(v) & 4'(h));
                exp_ma = !(n >= 1);
                exp_mm = !(n >= 2);
                @(negedge clk);
                entry_valid = 4'(v); entry_hit = 4'(h); cmp_stb = 1'b1;
                mi_n = 1'((v + h) & 1); full_en = 1'(h >> 1);
                @(negedge clk);
                cmp_stb = 1'b0;
                check("R1 ma_n after compare", ma_n, exp_ma);
                check("R2 mm_n after compare", mm_n, exp_mm);
                check("R9 mo_n", mo_n, mi_n & exp_ma);
                // Disturb the inputs without a strobe: the flags must hold.
                entry_hit = ~4'(h); entry_valid = 4'hF;
                mi_n = ~mi_n; full_en = ~full_en;
                @(negedge clk);
                check("R3 ma_n held", ma_n, exp_ma);
                check("R3 mm_n held", mm_n, exp_mm);
                check("R5 mm_n unaffected by mi_n/full_en", mm_n, exp_mm);
                check("R9 mo_n after mi_n flip", mo_n, mi_n & exp_ma);
                if (h == 15) begin
                    // Set change together with a three-hit compare: the clear wins.
                    entry_valid = 4'hF; entry_hit = 4'h7;
                    cmp_stb = 1'b1; set_chg = 1'b1;
                    @(negedge clk);
                    cmp_stb = 1'b0; set_chg = 1'b0;
                    check("R4 ma_n cleared", ma_n, 1'b1);
                    check("R4 mm_n cleared", mm_n, 1'b1);
                end
            end
        end

        // Full sweep: every empty vector, enable and full-in.
        for (int e = 0; e < 16; e++) begin
            for (int en = 0; en < 2; en++) begin
                for (int f = 0; f < 2; f++) begin
                    logic exp_fo, exp_nf;
                    @(negedge clk);
                    entry_empty = 4'(e); full_en = 1'(en); fi_n = 1'(f);
                    #1;
                    if (en == 1) exp_fo = !((e == 0) && (f == 0));
                    else         exp_fo = 1'(f);
                    exp_nf = (f == 0) && exp_fo;
                    if (en == 1) check("R6 fo_n enabled", fo_n, exp_fo);
                    else         check("R7 fo_n pass-through", fo_n, exp_fo);
                    check("R8 next_free", next_free, exp_nf);
                    if (en == 1 && f == 0)
                        check("R11 first device next_free", next_free, 1'(e != 0));
                end
            end
        end

        // First device with a held match: mo_n follows ma_n (R11).
        @(negedge clk);
        mi_n = 1'b1; fi_n = 1'b0; entry_valid = 4'h3; entry_hit = 4'h2; cmp_stb = 1'b1;
        @(negedge clk);
        cmp_stb = 1'b0;
        check("R11 ma_n low", ma_n, 1'b0);
        check("R11 mo_n follows ma_n", mo_n, 1'b0);
        check("R2 single hit keeps mm_n high", mm_n, 1'b1);

        // Synchronous reset mid-run (R10).
        entry_hit = 4'h3; cmp_stb = 1'b1;
        @(negedge clk);
        cmp_stb = 1'b0;
        check("R2 two hits", mm_n, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R10 no clear before edge", ma_n, 1'b0);
        @(negedge clk);
        check("R10 sync clear ma_n", ma_n, 1'b1);
        check("R10 sync clear mm_n", mm_n, 1'b1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule